// File: doc/BRIEF.md
# Single-Precision Step-Toward Unit

This block takes two single-precision operands, a start value `x` and a target `y`, and returns the representable value that sits directly next to `x` on the side facing `y`. For values of one sign, consecutive magnitudes are consecutive integers in the low 31 bits of the encoding. The unit therefore forms its result by adding or subtracting one on those bits and leaves the sign bit alone. It does not use a floating-point adder.

Some inputs are handled before the step. If either operand is NaN, the unit returns a canonical quiet NaN. If the operands are numerically equal, and signed zeros count as equal here, it returns `y` unchanged. If `x` is a zero, it returns the smallest denormal on the side of `y`. Because the step works on raw bit patterns, the same logic moves a value between denormals and normals, from the largest finite value up to infinity, and from the smallest denormal down to zero.

A caller presents both operands with a one-cycle `in_valid` strobe. The result appears one clock later together with `out_valid`. The result register holds its value until the next strobe.

Top module: `stw_nextafter`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each `in_valid` cycle and low otherwise. After reset, `out_valid` is 0.
- R2: A NaN has exponent field 255 (bits 30:23 all ones) and a nonzero fraction (bits 22:0). If either operand is NaN, the result is 0x7FC00000.
- R3: If neither operand is NaN and the two are numerically equal, the result is `y` bit for bit. This includes +0 (0x00000000) against -0 (0x80000000).
- R4: If `x` is a zero and `y` is different from it, the result is 0x00000001 when `y` is positive and 0x80000001 when `y` is negative.
- R5: If nonzero `x` moves away from zero, the low 31 bits are incremented and the sign bit (bit 31) is kept. For example, the largest denormal 0x007FFFFF steps up to the smallest normal 0x00800000.
- R6: The largest finite value 0x7F7FFFFF, stepped toward +infinity, gives 0x7F800000. The negative mirror 0xFF7FFFFF, stepped toward -infinity, gives 0xFF800000.
- R7: If nonzero `x` moves toward zero, the low 31 bits are decremented and the sign bit is kept. For example, the smallest normal steps down to the largest denormal, the smallest denormal steps down to a zero of the same sign, and an infinity steps down to the largest finite value.
- R8: The result register changes only in the cycle after an `in_valid` strobe. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| x_in | input | 32 | Start value |
| y_in | input | 32 | Target value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered adjacent value |

## Verification
The bench drives crossings at the format's boundaries:
- It steps from a zero into the smallest denormal of each sign. A design that ignores the sign of `y` would come out with the wrong sign.
- It steps between the largest denormal and the smallest normal, in both directions.
- It steps from the largest finite value to infinity, and from infinity back to the largest finite value.
- It presents signed zeros against each other. A design that compares raw bits would step instead of returning `y`.
- It presents negative operands. A design that orders them like unsigned integers would increment when it should decrement.
- It presents NaNs with various payloads. A design that checks only the exponent field would mistake an infinity for a NaN.

Random operands drawn from these classes cover the remaining combinations of sign and direction.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;

  typedef struct packed {
    logic is_nan;
    logic is_zero;
  } stw_class_t;
endpackage

// File: rtl/stw_rst_sync.sv
module stw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/stw_classify.sv
module stw_classify
  import stw_pkg::*;
#(
  parameter int EXP_W  = SP_EXP_W,
  parameter int FRAC_W = SP_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output stw_class_t   cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              sign_unused;

  always_comb begin
    {sign_unused, exp_f, frac_f} = op;
    cls.is_nan  = (&exp_f) && (|frac_f);
    cls.is_zero = ~|{exp_f, frac_f};
  end
endmodule

// File: rtl/stw_order.sv
module stw_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_zero,
  input  logic         b_zero,
  output logic         a_lt_b,
  output logic         a_eq_b
);
  logic [W-2:0] mag_a, mag_b;
  logic         sa, sb;

  always_comb begin
    sa     = a[W-1];
    sb     = b[W-1];
    mag_a  = a[W-2:0];
    mag_b  = b[W-2:0];
    a_eq_b = (a == b) || (a_zero && b_zero);
    if (sa != sb)     a_lt_b = sa && !(a_zero && b_zero);
    else if (!sa)     a_lt_b = mag_a < mag_b;
    else              a_lt_b = mag_a > mag_b;
  end
endmodule

// File: rtl/stw_step.sv
module stw_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic         away,
  output logic [W-1:0] stepped
);
  localparam logic [W-2:0] ONE = {{(W-2){1'b0}}, 1'b1};
  logic [W-2:0] mag_up, mag_dn;

  always_comb begin
    mag_up  = x[W-2:0] + ONE;
    mag_dn  = x[W-2:0] - ONE;
    stepped = {x[W-1], away ? mag_up : mag_dn};
  end
endmodule

// File: rtl/stw_nextafter.sv
module stw_nextafter
  import stw_pkg::*;
#(
  parameter int EXP_W  = SP_EXP_W,
  parameter int FRAC_W = SP_FRAC_W,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic         rst_sync_n;
  stw_class_t   cls [2];
  logic [W-1:0] ops [2];
  logic         x_lt_y, x_eq_y, any_nan, step_away;
  logic [W-1:0] stepped, res_d, res_q;
  logic         vld_d, vld_q;

  stw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  always_comb begin
    ops[0] = x_in;
    ops[1] = y_in;
  end

  for (genvar g = 0; g < 2; g++) begin : g_cls
    stw_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op(ops[g]), .cls(cls[g])
    );
  end

  stw_order #(.W(W)) u_ord (
    .a(x_in), .b(y_in),
    .a_zero(cls[0].is_zero), .b_zero(cls[1].is_zero),
    .a_lt_b(x_lt_y), .a_eq_b(x_eq_y)
  );

  always_comb step_away = x_lt_y ^ x_in[W-1];

  stw_step #(.W(W)) u_step (
    .x(x_in), .away(step_away), .stepped(stepped)
  );

  always_comb begin
    any_nan = cls[0].is_nan || cls[1].is_nan;
    if (any_nan)               res_d = QNAN;
    else if (x_eq_y)           res_d = y_in;
    else if (cls[0].is_zero)   res_d = {!x_lt_y, {(W-2){1'b0}}, 1'b1};
    else                       res_d = stepped;
    vld_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  p_nan_out_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && any_nan) |=> (result == QNAN));
  p_equal_y_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !any_nan && x_eq_y) |=> (result == $past(y_in)));
  p_zero_tiny_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !any_nan && !x_eq_y && cls[0].is_zero)
      |=> (result[W-2:0] == {{(W-2){1'b0}}, 1'b1}));
  p_sign_kept_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !any_nan && !x_eq_y && !cls[0].is_zero)
      |=> (result[W-1] == $past(x_in[W-1])));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(result));
endmodule

// File: tb/stw_nextafter_tb_top.sv
`timescale 1ns/1ps
module stw_nextafter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] x_in, y_in;
  logic        out_valid;
  logic [31:0] result;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;

  always #10 clk = ~clk;

  stw_nextafter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_in(x_in), .y_in(y_in), .out_valid(out_valid), .result(result)
  );

  function automatic bit m_nan(logic [31:0] a);
    return (a[30:23] == 8'hFF) && (a[22:0] != 0);
  endfunction
  function automatic bit m_zero(logic [31:0] a);
    return a[30:0] == 0;
  endfunction
  function automatic bit m_eq(logic [31:0] a, logic [31:0] b);
    return (a == b) || (m_zero(a) && m_zero(b));
  endfunction
  function automatic bit m_less(logic [31:0] a, logic [31:0] b);
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction
  function automatic logic [31:0] m_expect(logic [31:0] a, logic [31:0] b);
    if (m_nan(a) || m_nan(b)) return 32'h7FC00000;
    if (m_eq(a, b)) return b;
    if (m_zero(a)) return m_less(a, b) ? 32'h00000001 : 32'h80000001;
    if (m_less(a, b) != a[31]) return a + 32'd1;
    return a - 32'd1;
  endfunction
  function automatic string m_tag(logic [31:0] a, logic [31:0] b);
    if (m_nan(a) || m_nan(b)) return "R2";
    if (m_eq(a, b)) return "R3";
    if (m_zero(a)) return "R4";
    if (m_less(a, b) != a[31]) return "R5";
    return "R7";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, string tag);
    logic [31:0] e;
    e = m_expect(a, b);
    @(negedge clk);
    in_valid = 1'b1; x_in = a; y_in = b;
    @(negedge clk);
    in_valid = 1'b0; x_in = ~a; y_in = 32'h7FC00001;
    check("R1", {31'd0, out_valid}, 32'd1);
    check(tag, result, e);
    @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R8", result, e);
  endtask

  function automatic logic [31:0] pick(int unsigned r);
    case (r % 12)
      0: return 32'h00000000;
      1: return 32'h80000000;
      2: return 32'h00000001;
      3: return 32'h007FFFFF;
      4: return 32'h00800000;
      5: return 32'h7F7FFFFF;
      6: return 32'h7F800000;
      7: return 32'hFF800000;
      8: return {$urandom() % 2 == 0, 8'hFF, 23'h1 | 23'($urandom())};
      9: return 32'h3F800000 ^ {r[31], 31'd0};
      default: return $urandom();
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; x_in = '0; y_in = '0;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R8", result, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // directed corners
    apply(32'h7F7FFFFF, 32'h7F800000, "R6");
    apply(32'hFF7FFFFF, 32'hFF800000, "R6");
    apply(32'h7F800000, 32'h00000000, "R7");
    apply(32'h007FFFFF, 32'h3F800000, "R5");
    apply(32'h00800000, 32'h00000000, "R7");
    apply(32'h00000001, 32'hBF800000, "R7");
    apply(32'h80000001, 32'h3F800000, "R7");
    apply(32'h00000000, 32'h80000000, "R3");
    apply(32'h80000000, 32'h00000000, "R3");
    apply(32'h00000000, 32'h3F800000, "R4");
    apply(32'h80000000, 32'hBF800000, "R4");
    apply(32'h00000000, 32'h80000001, "R4");
    apply(32'hBF800000, 32'hC0000000, "R5");
    apply(32'hBF800000, 32'h3F800000, "R7");
    apply(32'h7F800001, 32'h3F800000, "R2");
    apply(32'h3F800000, 32'hFFC12345, "R2");
    apply(32'h7F800000, 32'h7F800000, "R3");
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = pick($urandom());
      case ($urandom() % 4)
        0:       b = a;
        1:       b = m_zero(a) ? {~a[31], a[30:0]} : pick($urandom());
        default: b = pick($urandom());
      endcase
      apply(a, b, m_tag(a, b));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule